// File: doc/BRIEF.md
# Dual-Plane Swappable Task-State Column

This block holds the flip-flop state of one column of reconfigurable logic as two parallel planes. Each state bit has two storage flops. At any moment one plane is active and the other is hidden. The active plane drives the user logic and loads its next state on every clock. The hidden plane is a serial shift chain that runs at the same time, so the context of the next task can be shifted in, and the context of the previous task shifted out, without halting the task that is running.

A single swap strobe exchanges the roles of the two planes in one clock. No data moves: a single toggle bit picks which flop of every pair is active, and that bit is exposed as status. A swap requested while the chain is shifting is refused and flagged, so a half-loaded context can never go live. The context path does not depend on any configuration, so a swap needs no configuration change. The column width and the end of the chain that feeds scan-out are parameters.

Top module: `ctxcol_column`

## Requirements
- R1: While reset is asserted and after it is released, both planes read as zero, `plane_sel` is 0 and `swap_rej` is 0.
- R2: On every clock edge the active plane loads `func_d`, even while the hidden chain shifts or a swap is refused. `func_q` always shows the active plane, so it equals the previous cycle's `func_d` after any edge that did not perform a swap.
- R3: An edge with `swap` high and `scan_en` low toggles `plane_sel`. After that edge, `func_q` equals the hidden plane's contents from before the edge. The task switch costs that one edge, and swaps on consecutive cycles each take effect. `plane_sel` = 0 means plane A (the first flop of each pair) is active.
- R4: With `scan_en` high, each edge shifts the hidden plane one place toward bit N-1 and loads `scan_in` into bit 0. `scan_out` shows hidden bit N-1 before the edge, so N shifts load a whole context, with the first bit shifted in ending up in bit N-1.
- R5: With `scan_en` and `swap` both low, the hidden plane holds its contents and `scan_out` does not change.
- R6: After an accepted swap, the hidden plane holds the `func_d` value that the outgoing task loaded on the swap edge. Shifting it out presents its bit N-1 first.
- R7: A swap requested while `scan_en` is high is ignored: `plane_sel` and the active data stay the same and the shift goes ahead. `swap_rej` is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_d | input | WIDTH | Next state from the user logic for the active plane |
| func_q | output | WIDTH | Current active-plane state fed to the user logic |
| scan_in | input | 1 | Serial input to the hidden-plane chain |
| scan_en | input | 1 | Shift the hidden chain by one place on this edge |
| scan_out | output | 1 | Hidden-plane bit at the chain output end |
| swap | input | 1 | Request to exchange the active and hidden planes |
| swap_rej | output | 1 | Pulse: the previous swap request was refused |
| plane_sel | output | 1 | Currently active plane (0 = A, 1 = B) |

## Verification
The bench shifts a context in while the active plane keeps loading changing values, swaps, and checks both the new active value and the old task's state coming out MSB first. A design that halted the active plane during a shift, or reversed the chain, fails these checks. It requests a swap in the middle of a shift and confirms that the plane select does not move, that the refusal flag pulses for exactly one cycle, and that the completed context still goes active intact later. A design that let a half-loaded context go live would show a wrong `func_q`. Swaps on consecutive cycles check that the first outgoing state comes back, which catches a design that copies data instead of toggling the select, or that drops the second swap. Idle stretches check that the hidden plane holds its value.

// File: rtl/ctxcol_pkg.sv
package ctxcol_pkg;

   typedef enum logic {
      PLANE_A = 1'b0,
      PLANE_B = 1'b1
   } plane_e;

   function automatic plane_e other_plane(input plane_e p);
      return (p == PLANE_A) ? PLANE_B : PLANE_A;
   endfunction

endpackage

// File: rtl/ctxcol_bitcell.sv
module ctxcol_bitcell
   import ctxcol_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  plane_e act_plane,
   input  logic   fd,
   input  logic   sin,
   input  logic   shift,
   output logic   q,
   output logic   hq
);

   logic ff_a;
   logic ff_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ff_a <= 1'b0;
         ff_b <= 1'b0;
      end else if (act_plane == PLANE_A) begin
         ff_a <= fd;
         if (shift) ff_b <= sin;
      end else begin
         ff_b <= fd;
         if (shift) ff_a <= sin;
      end
   end

   assign q  = (act_plane == PLANE_A) ? ff_a : ff_b;
   assign hq = (act_plane == PLANE_A) ? ff_b : ff_a;

endmodule

// File: rtl/ctxcol_ctrl.sv
module ctxcol_ctrl
   import ctxcol_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   swap_req,
   input  logic   shift_busy,
   output plane_e act_plane,
   output logic   swap_rej
);

   logic accept;
   assign accept = swap_req & ~shift_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_plane <= PLANE_A;
         swap_rej  <= 1'b0;
      end else begin
         if (accept) act_plane <= other_plane(act_plane);
         swap_rej <= swap_req & shift_busy;
      end
   end

endmodule

// File: rtl/ctxcol_column.sv
module ctxcol_column
   import ctxcol_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit SCAN_OUT_MSB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] func_d,
   output logic [WIDTH-1:0] func_q,
   input  logic             scan_in,
   input  logic             scan_en,
   output logic             scan_out,
   input  logic             swap,
   output logic             swap_rej,
   output logic             plane_sel
);

   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ctxcol_column: WIDTH must be at least 2");
   end

   plane_e           act_plane;
   logic [WIDTH:0]   chain;

   ctxcol_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_req   (swap),
      .shift_busy (scan_en),
      .act_plane  (act_plane),
      .swap_rej   (swap_rej)
   );

   assign chain[0] = scan_in;

   for (genvar p = 0; p < WIDTH; p++) begin : g_cell
      localparam int IDX = SCAN_OUT_MSB ? p : (LAST - p);
      ctxcol_bitcell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_plane (act_plane),
         .fd        (func_d[IDX]),
         .sin       (chain[p]),
         .shift     (scan_en),
         .q         (func_q[IDX]),
         .hq        (chain[p+1])
      );
   end

   assign scan_out  = chain[WIDTH];
   assign plane_sel = act_plane;

endmodule

// File: rtl/ctxcol_column_chk.sv
module ctxcol_column_chk #(
   parameter int WIDTH        = 8,
   parameter bit SCAN_OUT_MSB = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] func_d,
   input logic [WIDTH-1:0] func_q,
   input logic             scan_en,
   input logic             scan_out,
   input logic             swap,
   input logic             swap_rej,
   input logic             plane_sel
);

   AST_ACTIVE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !(swap && !scan_en) |=> func_q == $past(func_d)); // R2

   AST_SWAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && !scan_en) |=> plane_sel != $past(plane_sel)); // R3

   AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(plane_sel)); // R3

   AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en && !swap) |=> $stable(scan_out)); // R5

   AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && scan_en) |=> swap_rej && $stable(plane_sel)); // R7

   AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(swap && scan_en) |=> !swap_rej); // R7

   if (SCAN_OUT_MSB) begin : g_old_state
      AST_SWAP_OLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
         (swap && !scan_en) |=> scan_out == $past(func_d[WIDTH-1])); // R6
   end

endmodule

bind ctxcol_column ctxcol_column_chk #(
   .WIDTH        (WIDTH),
   .SCAN_OUT_MSB (SCAN_OUT_MSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .func_d    (func_d),
   .func_q    (func_q),
   .scan_en   (scan_en),
   .scan_out  (scan_out),
   .swap      (swap),
   .swap_rej  (swap_rej),
   .plane_sel (plane_sel)
);

// File: tb/ctxcol_column_tb.sv
module ctxcol_column_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] func_d;
   logic [W-1:0] func_q;
   logic         scan_in;
   logic         scan_en;
   logic         scan_out;
   logic         swap;
   logic         swap_rej;
   logic         plane_sel;

   int n_chk  = 0;
   int n_fail = 0;

   logic [W-1:0] m_hidden;
   logic         m_sel;

   always #5 clk = ~clk;

   ctxcol_column #(.WIDTH(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .func_d    (func_d),
      .func_q    (func_q),
      .scan_in   (scan_in),
      .scan_en   (scan_en),
      .scan_out  (scan_out),
      .swap      (swap),
      .swap_rej  (swap_rej),
      .plane_sel (plane_sel)
   );

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   // shift a full context in; returns what came out (MSB first)
   task automatic shift_ctx(input logic [W-1:0] v_in, input logic [W-1:0] fd_seed,
                            output logic [W-1:0] v_out);
      for (int k = 0; k < W; k++) begin
         scan_en = 1'b1;
         scan_in = v_in[W-1-k];
         func_d  = fd_seed + W'(k * 37);
         check_eq("R4 scan_out shows hidden msb", scan_out, m_hidden[W-1]);
         v_out[W-1-k] = scan_out;
         tick;
         check_eq("R2 capture during shift", func_q, func_d);
         m_hidden = {m_hidden[W-2:0], v_in[W-1-k]};
      end
      scan_en = 1'b0;
   endtask

   task automatic do_swap(input logic [W-1:0] fd);
      logic [W-1:0] was_hidden;
      was_hidden = m_hidden;
      swap    = 1'b1;
      scan_en = 1'b0;
      func_d  = fd;
      tick;
      swap  = 1'b0;
      m_sel = ~m_sel;
      check_eq("R3 func_q takes hidden after swap", func_q, was_hidden);
      check_eq("R3 plane_sel toggles", plane_sel, m_sel);
      check_eq("R6 old state at chain end", scan_out, fd[W-1]);
      m_hidden = fd;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; func_d = '1; scan_in = 1'b1; scan_en = 1'b1; swap = 1'b1;
      tick; tick;
      check_eq("R1 func_q in reset", func_q, 0);
      check_eq("R1 plane_sel in reset", plane_sel, 0);
      check_eq("R1 swap_rej in reset", swap_rej, 0);
      scan_en = 1'b0; swap = 1'b0; func_d = '0; scan_in = 1'b0;
      rst_n = 1'b1;
      tick;
      check_eq("R1 scan_out after reset", scan_out, 0);
      check_eq("R1 plane_sel after reset", plane_sel, 0);
      m_hidden = '0; m_sel = 1'b0;
   endtask

   task automatic t_swap_flow;
      logic [W-1:0] got;
      shift_ctx(8'hA5, 8'h10, got);
      check_eq("R4 initial hidden shifted out", got, 8'h00);
      do_swap(8'h3C);
      shift_ctx(8'h96, 8'h44, got);
      check_eq("R6 outgoing task state shifted out", got, 8'h3C);
      do_swap(8'h0F);
      check_eq("R3 back to plane A", plane_sel, 0);
   endtask

   task automatic t_hold;
      logic [W-1:0] held;
      held = m_hidden;
      for (int i = 0; i < 10; i++) begin
         func_d = W'(i * 29 + 3);
         tick;
         check_eq("R5 hidden holds while idle", scan_out, held[W-1]);
         check_eq("R2 capture while idle", func_q, func_d);
      end
      do_swap(8'hC3);
      check_eq("R5 context intact after idle", func_q, held);
   endtask

   task automatic t_reject;
      logic [W-1:0] ctx;
      ctx = 8'h5E;
      for (int k = 0; k < W; k++) begin
         scan_en = 1'b1;
         scan_in = ctx[W-1-k];
         func_d  = W'(k * 13 + 1);
         swap    = (k == 2);
         tick;
         m_hidden = {m_hidden[W-2:0], ctx[W-1-k]};
         if (k == 2) begin
            check_eq("R7 plane_sel unchanged on refused swap", plane_sel, m_sel);
            check_eq("R7 swap_rej raised", swap_rej, 1);
            check_eq("R7 active keeps capturing", func_q, func_d);
         end
         if (k == 3) check_eq("R7 swap_rej lasts one cycle", swap_rej, 0);
         swap = 1'b0;
      end
      scan_en = 1'b0;
      do_swap(8'h81);
      check_eq("R7 completed context goes active", func_q, ctx);
   endtask

   task automatic t_back_to_back;
      logic [W-1:0] h0;
      h0 = m_hidden;
      do_swap(8'h6B);
      check_eq("R3 first of back-to-back", func_q, h0);
      do_swap(8'hD2);
      check_eq("R3 second swap returns outgoing state", func_q, 8'h6B);
      check_eq("R6 hidden has second outgoing state", scan_out, 1'b1);
   endtask

   initial begin
      scan_en = 1'b0; swap = 1'b0; func_d = '0; scan_in = 1'b0; rst_n = 1'b0;
      t_reset();
      t_swap_flow();
      t_hold();
      t_reject();
      t_back_to_back();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule